// File: doc/BRIEF.md
# NAND Byte-Pair Bus Bridge

This block sits between a synchronous 16-bit register port and an 8-bit raw NAND flash device. Software selects the flash bus phase by writing an encoded value into a byte-wide phase register. That register drives chip enable, the command latch line and the address latch line. Accesses to the data window then turn into NAND read or write strobes. A 16-bit data access runs two byte cycles back to back. A byte-wide access runs a single cycle, which is how command and address bytes are issued.

A status register shows whether the flash is busy. An event register latches each busy-to-ready transition of the ready/busy line. A mask register decides which latched events reach the interrupt pin. Software clears the event flag by writing a 1 to it.

The register port is a valid/ready request channel. The requester raises `req_valid` with address, direction, width and write data, and holds all of them steady until it sees `req_ready` high at a clock edge. `req_ready` is the completion of the access, and read data on `rsp_rdata` is valid in that same cycle. Non-data registers complete in the cycle the request appears. Data-window accesses keep `req_ready` low until the last NAND byte cycle has finished. That stall is the only back-pressure. The requester must drop `req_valid` after the completing edge unless it intends a new access.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale, nand_dq_oe and irq are low, and the phase register at offset 4 reads 0x00.
- R2: The phase register (offset 4, byte) drives chip enable from bit 4 (nand_ce_n = not bit 4), ALE from bit 1 and CLE from bit 0, and reads back as written. Thus 0x94 selects data phase, 0x95 command phase (CLE high), 0x96 address phase (ALE high), and 0x00 standby (chip disabled).
- R3: A byte-wide (req_wide=0) write to the data window (offset 0) produces exactly one NAND write strobe, carrying req_wdata[7:0].
- R4: A 16-bit (req_wide=1) write to the data window produces two write strobes: req_wdata[7:0] first, then req_wdata[15:8].
- R5: A 16-bit read of the data window returns the first flash byte in bits 7:0 and the second in bits 15:8. A byte-wide read runs one read strobe and returns the byte in bits 7:0 with bits 15:8 zero.
- R6: Each NAND byte cycle has one clock of setup with strobes high, then the strobe held low for STROBE_CLKS clocks (default 2), then one clock of hold. During a write, nand_dq_oe stays high until the strobe has risen.
- R7: A data-window access completes (req_ready high) in the STROBE_CLKS+3rd cycle of the request when byte-wide, and in the 2*STROBE_CLKS+5th cycle when 16-bit. Any other offset completes in the first cycle.
- R8: Status register (offset 5) bit 7 reads 1 while nand_rb is low (busy), after a two-flop synchronizer. The other bits read 0.
- R9: A low-to-high transition of the synchronized nand_rb sets event bit 0 at offset 6. The bit stays set until software writes a 1 to bit 0 (for example 0x0F). The synchronizer resets to "ready", so no event follows reset.
- R10: irq is the OR of the event bits that are set and whose mask bit at offset 7 is 1. Writing 0x81 to the mask enables the ready event and 0x00 disables it, without clearing the event flag.
- R11: nand_we_n and nand_re_n are never low together, and nand_dq_oe is never high during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request completes this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Data window: 1 = 16-bit, 0 = byte |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid with req_ready |
| irq | output | 1 | Interrupt request |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to flash |
| nand_dq_oe | output | 1 | Enable for the flash data driver |
| nand_dq_in | input | 8 | Byte returned by flash |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
The checks assume a requester that keeps every request field steady from the raise of req_valid until the completing edge. They also assume it drops req_valid before the next edge, so no access is started twice. The flash model drives nand_dq_in on the falling read strobe and never changes it before the sampling edge. The ready/busy line moves only at clock-unrelated moments and stays put for several clocks, which is what the synchronizer needs. The bench keeps to these rules: inputs change on the falling clock edge, and valid is released one time unit after the completing rising edge.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_MODE = 3'd4;
  localparam logic [2:0] OFS_STAT = 3'd5;
  localparam logic [2:0] OFS_EVT  = 3'd6;
  localparam logic [2:0] OFS_MASK = 3'd7;

  localparam int MODE_CLE_BIT  = 0;
  localparam int MODE_ALE_BIT  = 1;
  localparam int MODE_CE_BIT   = 4;
  localparam int STAT_BUSY_BIT = 7;

endpackage

// File: rtl/nbb_rb_sync.sv
module nbb_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_ready,
  output logic rb_rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], rb_async};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rb_ready = chain_q[STAGES-1];
  assign rb_rise  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
  import nbb_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             rb_ready,
  input  logic             rb_rise,
  output logic [REG_W-1:0] rdata,
  output logic             ce_on,
  output logic             cle,
  output logic             ale,
  output logic             irq
);

  logic [REG_W-1:0] phase_q;
  logic [REG_W-1:0] mask_q;
  logic             ready_evt_q;
  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] stat_vec;
  logic             evt_clr;

  assign evt_clr = wr_en && (addr == OFS_EVT) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= '0;
      mask_q      <= '0;
      ready_evt_q <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_MODE) phase_q <= wdata;
      if (wr_en && addr == OFS_MASK) mask_q  <= wdata;
      if (rb_rise)      ready_evt_q <= 1'b1;
      else if (evt_clr) ready_evt_q <= 1'b0;
    end
  end

  always_comb begin
    evt_vec    = '0;
    evt_vec[0] = ready_evt_q;
    stat_vec   = '0;
    stat_vec[STAT_BUSY_BIT] = ~rb_ready;
  end

  always_comb begin
    case (addr)
      OFS_MODE: rdata = phase_q;
      OFS_STAT: rdata = stat_vec;
      OFS_EVT:  rdata = evt_vec;
      OFS_MASK: rdata = mask_q;
      default:  rdata = '0;
    endcase
  end

  assign ce_on = phase_q[MODE_CE_BIT];
  assign cle   = phase_q[MODE_CLE_BIT];
  assign ale   = phase_q[MODE_ALE_BIT];
  assign irq   = |(evt_vec & mask_q);

  // R9
  evt_sets_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> ready_evt_q);

  // R9
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_evt_q && !evt_clr) |=> ready_evt_q);

  // R10
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK && wdata == '0) |=> !irq);

endmodule

// File: rtl/nbb_byte_seq.sv
module nbb_byte_seq
  import nbb_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [BYTE_W-1:0] dq_in,
  output logic              idle,
  output logic              done,
  output logic [BUS_W-1:0]  rdata,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int NBYTES = BUS_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_W  = $clog2(STROBE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wide_q;
  logic              wr_q;
  logic [BUS_W-1:0]  wdata_q;
  logic [BUS_W-1:0]  rdata_q;
  logic              at_last;

  assign at_last = wide_q ? (idx_q == IDX_LAST) : (idx_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETUP;
            idx_q   <= '0;
            wide_q  <= wide;
            wr_q    <= wr;
            wdata_q <= wdata;
            rdata_q <= '0;
          end
        end
        PH_SETUP: begin
          phase_q <= PH_STROBE;
          cnt_q   <= '0;
        end
        PH_STROBE: begin
          if (cnt_q == CNT_LAST) begin
            phase_q <= PH_HOLD;
            if (!wr_q) rdata_q[idx_q*BYTE_W +: BYTE_W] <= dq_in;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (at_last) begin
            phase_q <= PH_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            phase_q <= PH_SETUP;
          end
        end
      endcase
    end
  end

  assign idle   = (phase_q == PH_IDLE);
  assign done   = (phase_q == PH_HOLD) && at_last;
  assign rdata  = rdata_q;
  assign we_n   = !((phase_q == PH_STROBE) && wr_q);
  assign re_n   = !((phase_q == PH_STROBE) && !wr_q);
  assign dq_oe  = wr_q && (phase_q != PH_IDLE);
  assign dq_out = dq_oe ? wdata_q[idx_q*BYTE_W +: BYTE_W] : '0;

  logic             sv_act;
  logic [CNT_W:0]   sv_low_cnt;

  assign sv_act = !we_n || !re_n;

  always_ff @(posedge clk) begin
    if (!rst_n)      sv_low_cnt <= '0;
    else if (sv_act) sv_low_cnt <= sv_low_cnt + 1'b1;
    else             sv_low_cnt <= '0;
  end

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_act && $past(sv_act)) |-> (sv_low_cnt == (CNT_W+1)'(STROBE_CLKS)));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R11
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !re_n));

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int STROBE_CLKS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [2:0]        req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              irq,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [BYTE_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [BYTE_W-1:0] nand_dq_in,
  input  logic              nand_rb
);

  logic              is_data;
  logic              seq_idle;
  logic              seq_done;
  logic              seq_start;
  logic [BUS_W-1:0]  seq_rdata;
  logic              reg_wr;
  logic [BYTE_W-1:0] reg_rdata;
  logic              rb_ready;
  logic              rb_rise;
  logic              ce_on;

  assign is_data   = (req_addr == OFS_DATA);
  assign seq_start = req_valid && is_data && seq_idle;
  assign req_ready = seq_done || (req_valid && !is_data && seq_idle);
  assign reg_wr    = req_valid && req_ready && req_write && !is_data;
  assign rsp_rdata = is_data ? seq_rdata : {{(BUS_W-BYTE_W){1'b0}}, reg_rdata};
  assign nand_ce_n = ~ce_on;

  nbb_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_async (nand_rb),
    .rb_ready (rb_ready),
    .rb_rise  (rb_rise)
  );

  nbb_regs #(.REG_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (req_addr),
    .wdata    (req_wdata[BYTE_W-1:0]),
    .rb_ready (rb_ready),
    .rb_rise  (rb_rise),
    .rdata    (reg_rdata),
    .ce_on    (ce_on),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .irq      (irq)
  );

  nbb_byte_seq #(
    .BUS_W       (BUS_W),
    .BYTE_W      (BYTE_W),
    .STROBE_CLKS (STROBE_CLKS)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_start),
    .wide   (req_wide),
    .wr     (req_write),
    .wdata  (req_wdata),
    .dq_in  (nand_dq_in),
    .idle   (seq_idle),
    .done   (seq_done),
    .rdata  (seq_rdata),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .dq_out (nand_dq_out),
    .dq_oe  (nand_dq_oe)
  );

  // R2
  standby_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && req_addr == OFS_MODE && !req_wdata[MODE_CE_BIT]) |=> nand_ce_n);

  // R7
  data_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_data && seq_idle) |-> !req_ready);

endmodule

// File: tb/sim_nand_bus_bridge.sv
module sim_nand_bus_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int STROBE     = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic [15:0] req_wdata = 16'h0;
  logic [15:0] rsp_rdata;
  logic        irq;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb = 1'b1;

  int vectors = 0;
  int fails = 0;

  logic [7:0] wr_log [0:15];
  logic       wr_cle [0:15];
  logic       wr_oe  [0:15];
  int         wr_cnt = 0;
  logic [7:0] rd_mem [0:7];
  int         rd_ptr = 0;
  int         re_cnt = 0;
  int         low_run = 0;
  int         last_width = 0;
  int         oe_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_bridge #(.STROBE_CLKS(STROBE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  // flash model
  always @(posedge nand_we_n) begin
    if (rst_n === 1'b1 && wr_cnt < 16) begin
      wr_log[wr_cnt] = nand_dq_out;
      wr_cle[wr_cnt] = nand_cle;
      wr_oe[wr_cnt]  = nand_dq_oe;
      wr_cnt = wr_cnt + 1;
    end
  end

  always @(negedge nand_re_n) begin
    if (rst_n === 1'b1) begin
      nand_dq_in = rd_mem[rd_ptr % 8];
      rd_ptr = rd_ptr + 1;
      re_cnt = re_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (nand_we_n === 1'b0 || nand_re_n === 1'b0) low_run = low_run + 1;
    else if (low_run != 0) begin
      last_width = low_run;
      low_run = 0;
    end
    if (nand_dq_oe === 1'b1 && nand_re_n === 1'b0) oe_viol = oe_viol + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic wide, input logic [2:0] addr,
                     input logic [15:0] wd, output logic [15:0] rd, output int n);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_wide  = wide;
    req_addr  = addr;
    req_wdata = wd;
    #1;
    n = 1;
    while (req_ready !== 1'b1) begin
      @(negedge clk);
      #1;
      n++;
    end
    rd = rsp_rdata;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic reg_wr(input logic [2:0] addr, input logic [7:0] v);
    logic [15:0] rd;
    int n;
    bus(1'b1, 1'b0, addr, {8'h00, v}, rd, n);
  endtask

  task automatic reg_rd(input logic [2:0] addr, output logic [7:0] v);
    logic [15:0] rd;
    int n;
    bus(1'b0, 1'b0, addr, 16'h0, rd, n);
    v = rd[7:0];
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    check("R1 ce_n", nand_ce_n, 1);
    check("R1 cle", nand_cle, 0);
    check("R1 ale", nand_ale, 0);
    check("R1 we_n", nand_we_n, 1);
    check("R1 re_n", nand_re_n, 1);
    check("R1 dq_oe", nand_dq_oe, 0);
    check("R1 irq", irq, 0);
    reg_rd(3'd4, v);
    check("R1 phase reg", v, 8'h00);
  endtask

  task automatic t_phase;
    logic [7:0] v;
    reg_wr(3'd4, 8'h95);
    @(negedge clk);
    check("R2 cmd cle", nand_cle, 1);
    check("R2 cmd ale", nand_ale, 0);
    check("R2 cmd ce_n", nand_ce_n, 0);
    reg_rd(3'd4, v);
    check("R2 readback", v, 8'h95);
    reg_wr(3'd4, 8'h96);
    @(negedge clk);
    check("R2 addr ale", nand_ale, 1);
    check("R2 addr cle", nand_cle, 0);
    reg_wr(3'd4, 8'h94);
    @(negedge clk);
    check("R2 data cle/ale", {nand_cle, nand_ale}, 2'b00);
    check("R2 data ce_n", nand_ce_n, 0);
    reg_wr(3'd4, 8'h00);
    @(negedge clk);
    check("R2 standby ce_n", nand_ce_n, 1);
  endtask

  task automatic t_cmd_byte;
    logic [15:0] rd;
    int n;
    reg_wr(3'd4, 8'h95);
    wr_cnt = 0;
    bus(1'b1, 1'b0, 3'd0, 16'hAA70, rd, n);
    repeat (2) @(negedge clk);
    check("R3 strobe count", wr_cnt, 1);
    check("R3 byte", wr_log[0], 8'h70);
    check("R2 cle during cmd", wr_cle[0], 1);
    check("R7 byte latency", n, STROBE + 3);
    check("R6 strobe width", last_width, STROBE);
    check("R6 oe through strobe rise", wr_oe[0], 1);
    bus(1'b0, 1'b0, 3'd5, 16'h0, rd, n);
    check("R7 reg latency", n, 1);
  endtask

  task automatic t_wide_write;
    logic [15:0] rd;
    int n;
    reg_wr(3'd4, 8'h94);
    wr_cnt = 0;
    bus(1'b1, 1'b1, 3'd0, 16'hBEEF, rd, n);
    repeat (2) @(negedge clk);
    check("R4 strobe count", wr_cnt, 2);
    check("R4 first low", wr_log[0], 8'hEF);
    check("R4 second high", wr_log[1], 8'hBE);
    check("R7 wide latency", n, 2*STROBE + 5);
    check("R1 oe released", nand_dq_oe, 0);
  endtask

  task automatic t_reads;
    logic [15:0] rd;
    int n;
    rd_mem[0] = 8'h12; rd_mem[1] = 8'h34; rd_mem[2] = 8'h5A;
    rd_ptr = 0; re_cnt = 0; wr_cnt = 0; oe_viol = 0;
    bus(1'b0, 1'b1, 3'd0, 16'h0, rd, n);
    check("R5 wide read", rd, 16'h3412);
    check("R5 read strobes", re_cnt, 2);
    check("R7 wide read latency", n, 2*STROBE + 5);
    check("R6 read strobe width", last_width, STROBE);
    bus(1'b0, 1'b0, 3'd0, 16'h0, rd, n);
    check("R5 byte read", rd, 16'h005A);
    check("R5 byte read strobes", re_cnt, 3);
    check("R11 no writes on read", wr_cnt, 0);
    check("R11 no drive on read", oe_viol, 0);
  endtask

  task automatic t_ready_event;
    logic [7:0] v;
    reg_rd(3'd6, v);
    check("R9 no event after reset", v, 8'h00);
    @(negedge clk) nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    reg_rd(3'd5, v);
    check("R8 busy", v, 8'h80);
    reg_wr(3'd6, 8'h0F);
    reg_wr(3'd7, 8'h81);
    check("R10 no irq while busy", irq, 0);
    @(negedge clk) nand_rb = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 irq on ready", irq, 1);
    reg_rd(3'd6, v);
    check("R9 event set", v, 8'h01);
    reg_rd(3'd5, v);
    check("R8 ready", v, 8'h00);
    repeat (6) @(negedge clk);
    reg_rd(3'd6, v);
    check("R9 sticky", v, 8'h01);
    reg_wr(3'd7, 8'h00);
    @(negedge clk);
    check("R10 masked", irq, 0);
    reg_rd(3'd6, v);
    check("R10 mask keeps flag", v, 8'h01);
    reg_wr(3'd6, 8'h0F);
    reg_rd(3'd6, v);
    check("R9 cleared", v, 8'h00);
    reg_wr(3'd7, 8'h81);
    @(negedge clk);
    check("R10 no irq without event", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_phase();
    t_cmd_byte();
    t_wide_write();
    t_reads();
    t_ready_event();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule